// File: doc/BRIEF.md
# Precise Exception Retirement Controller

This block sits at the retirement end of a processor that completes instructions in order. It decides in which cycle an exception is taken, which vector it uses, and what is saved for the return. It watches the head entry of the completion queue. The head is a valid/ready stream: the queue presents an entry with `head_valid`, and the block accepts (retires) it by raising `head_ready`. The block also takes two maskable asynchronous requests (external and timer) and two nonmaskable ones (reset and machine check).

Faults raised by instructions are taken only when the faulting entry reaches the head, so every older instruction has retired first. Maskable requests are held until the head instruction finishes, or until the queue is empty. Only one exception is in progress at a time, from the take until `ret_valid`. Reset and machine check may break into an exception already in progress.

When an exception is taken, the block does four things in the same cycle: it pulses `take_o` and `flush_o`, it presents the vector offset, and it presents the capture values for the restart address and for the machine-state copy. On the next clock edge, the interrupt-enable and recoverable bits of the live machine state are cleared.

Back-pressure rules: an entry stays at the head, unchanged, until the block raises `head_ready`. The block never raises `head_ready` in these cases:
- the head is still executing;
- the head carries a fault;
- reset or machine check is taken in that cycle.

Top module: `exc_retire_ctrl`

## Requirements
- R1: A head entry with `head_valid`, `head_done` and `head_exc` all set is taken when no exception is in progress. In that cycle `head_ready` stays 0. For data-access (cause 0), program (cause 1) and floating-point (cause 2) faults, `srr0_o` equals `head_pc`.
- R2: For trap (cause 3) and system call (cause 4), `srr0_o` equals `head_pc` + 4.
- R3: A floating-point fault is taken at the head in the same way whatever the other machine-state bits hold, including the floating-point mode bits (bits 11 and 8). Its vector is 0x700.
- R4: External and timer requests are taken only when all of these hold:
  - the interrupt-enable bit (bit 15) of the live machine state is 1;
  - no exception is in progress;
  - either the queue is empty, with `srr0_o` = `fetch_pc`, or the head retires in that same cycle, with `srr0_o` = `head_npc`.
- R5: When several sources are eligible in one cycle, the fixed priority is: reset, then machine check, then the head fault, then external, then timer.
- R6: From a take until `ret_valid`, head faults and maskable requests are not taken. The head entry holding a fault is held, not retired.
- R7: Reset and machine check are taken even while an exception is in progress. Their `srr0_o` is `head_pc` when the head is valid, and `fetch_pc` otherwise.
- R8: On a take, `srr1_o` equals the machine state before the exception. On the next edge, bits 15 (interrupt enable) and 1 (recoverable) of `msr_o` become 0. `ret_valid` loads `ret_msr` into `msr_o` and ends the exception in progress.
- R9: `flush_o` is high exactly in the cycles where `take_o` is high. A machine-check, external or timer request that is not taken stays pending until it is taken.
- R10: Vector offsets are as follows. Any cause code not listed here uses 0x700.

  | Source | Vector |
  |---|---|
  | Reset | 0x100 |
  | Machine check | 0x200 |
  | Data access (cause 0) | 0x300 |
  | External | 0x500 |
  | Program, floating point, trap (causes 1 to 3) | 0x700 |
  | Timer | 0x900 |
  | System call (cause 4) | 0xC00 |

- R11: `head_ready` is 1 only when all of these hold: `head_valid` and `head_done` are set, `head_exc` is clear, and no reset or machine check is taken in that cycle.
- R12: After `rst_n` is released, `msr_o` is 0, no exception is in progress, no request is pending and `take_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| head_valid | input | 1 | Completion-queue head entry present |
| head_ready | output | 1 | Head entry retires this cycle |
| head_done | input | 1 | Head entry has finished execution |
| head_exc | input | 1 | Head entry carries a fault |
| head_cause | input | 4 | Fault cause code of the head |
| head_pc | input | 32 | Address of the head instruction |
| head_npc | input | 32 | Address of the instruction after the head |
| fetch_pc | input | 32 | Next fetch address, used when the queue is empty |
| rst_req | input | 1 | Soft reset request pulse |
| mck_req | input | 1 | Machine check request pulse |
| ext_req | input | 1 | External interrupt request pulse |
| dec_req | input | 1 | Timer (decrementer) request pulse |
| ret_valid | input | 1 | Return from handler |
| ret_msr | input | 32 | Machine state restored on return |
| take_o | output | 1 | Exception taken this cycle |
| flush_o | output | 1 | Discard all queue entries |
| vec_o | output | 12 | Vector offset |
| srr0_o | output | 32 | Restart address to capture |
| srr1_o | output | 32 | Pre-exception machine state to capture |
| msr_o | output | 32 | Live machine state |

## Verification
The bench targets several corner cases, each with a distinct wrong behaviour:
- An external request that arrives while the head is still executing. A design that ignored the wait would take it early and save the wrong restart address.
- The same request once the head finishes. It must be taken in the retiring cycle with the successor address, so a design that dropped the latch would lose it.
- A cycle in which reset, machine check, a head fault and an external request all coincide. After it, each of the lower sources must come out in turn in later cycles. A wrong priority or a lost pending bit shows up as a wrong vector sequence.
- An exception in progress. A design without the in-progress gate would nest a second synchronous or maskable entry, and one that gated too much would block machine check.
- The trap/system-call addressing and the floating-point mode bits are each exercised on their own.

A long randomized phase is then compared cycle by cycle with a behavioural model.

// File: rtl/exc_retire_pkg.sv
package exc_retire_pkg;

  localparam int VEC_W = 12;

  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_RST  = 3'd1,
    SRC_MCK  = 3'd2,
    SRC_SYNC = 3'd3,
    SRC_EXT  = 3'd4,
    SRC_DEC  = 3'd5
  } exc_src_e;

  localparam logic [VEC_W-1:0] VEC_RESET   = 12'h100;
  localparam logic [VEC_W-1:0] VEC_MCHECK  = 12'h200;
  localparam logic [VEC_W-1:0] VEC_DACCESS = 12'h300;
  localparam logic [VEC_W-1:0] VEC_EXTIRQ  = 12'h500;
  localparam logic [VEC_W-1:0] VEC_PROGRAM = 12'h700;
  localparam logic [VEC_W-1:0] VEC_TIMER   = 12'h900;
  localparam logic [VEC_W-1:0] VEC_SYSCALL = 12'hC00;

  localparam int CAUSE_DACCESS = 0;
  localparam int CAUSE_PROGRAM = 1;
  localparam int CAUSE_FLOAT   = 2;
  localparam int CAUSE_TRAP    = 3;
  localparam int CAUSE_SYSCALL = 4;

  // vector for an instruction-caused fault
  function automatic logic [VEC_W-1:0] sync_vector(input int unsigned cause);
    case (cause)
      CAUSE_DACCESS: sync_vector = VEC_DACCESS;
      CAUSE_SYSCALL: sync_vector = VEC_SYSCALL;
      default:       sync_vector = VEC_PROGRAM;
    endcase
  endfunction

  // trap and system call resume past the instruction
  function automatic logic resumes_after(input int unsigned cause);
    resumes_after = (cause == CAUSE_TRAP) || (cause == CAUSE_SYSCALL);
  endfunction

endpackage

// File: rtl/exc_async_latch.sv
module exc_async_latch #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic [N-1:0] clr,
  output logic [N-1:0] eff
);
  logic [N-1:0] pend_q;

  for (genvar i = 0; i < N; i++) begin : g_src
    assign eff[i] = pend_q[i] | req[i];

    always_ff @(posedge clk) begin
      if (!rst_n) pend_q[i] <= 1'b0;
      else        pend_q[i] <= eff[i] & ~clr[i];
    end

    assert_pending_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (eff[i] && !clr[i]) |=> pend_q[i]);
  end
endmodule

// File: rtl/exc_msr_state.sv
module exc_msr_state #(
  parameter int          MW        = 32,
  parameter int          EE_BIT    = 15,
  parameter int          RI_BIT    = 1,
  parameter logic [MW-1:0] RESET_MSR = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic          ret_valid,
  input  logic [MW-1:0] ret_msr,
  output logic [MW-1:0] msr_q,
  output logic          busy_q
);
  localparam logic [MW-1:0] CLR_MASK = ~((MW'(1) << EE_BIT) | (MW'(1) << RI_BIT));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msr_q  <= RESET_MSR;
      busy_q <= 1'b0;
    end else if (take) begin
      msr_q  <= msr_q & CLR_MASK;
      busy_q <= 1'b1;
    end else if (ret_valid) begin
      msr_q  <= ret_msr;
      busy_q <= 1'b0;
    end
  end

  assert_msr_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (!msr_q[EE_BIT] && !msr_q[RI_BIT] && busy_q));
endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_retire_pkg::*;
#(
  parameter int AW   = 32,
  parameter int CW   = 4,
  parameter int ILEN = 4
) (
  input  logic                head_valid,
  input  logic                head_done,
  input  logic                head_exc,
  input  logic [CW-1:0]       head_cause,
  input  logic [AW-1:0]       head_pc,
  input  logic [AW-1:0]       head_npc,
  input  logic [AW-1:0]       fetch_pc,
  input  logic                rst_req,
  input  logic                mck_eff,
  input  logic                ext_eff,
  input  logic                dec_eff,
  input  logic                ee,
  input  logic                busy,
  output exc_src_e            src,
  output logic                head_ready,
  output logic [VEC_W-1:0]    vec,
  output logic [AW-1:0]       srr0
);
  logic sync_ok, async_win, nmi;
  int unsigned cause_u;

  assign cause_u   = int'(head_cause);
  assign sync_ok   = head_valid && head_done && head_exc && !busy;
  assign async_win = ee && !busy && (!head_valid || (head_done && !head_exc));

  always_comb begin
    if (rst_req)                    src = SRC_RST;
    else if (mck_eff)               src = SRC_MCK;
    else if (sync_ok)               src = SRC_SYNC;
    else if (async_win && ext_eff)  src = SRC_EXT;
    else if (async_win && dec_eff)  src = SRC_DEC;
    else                            src = SRC_NONE;
  end

  assign nmi        = (src == SRC_RST) || (src == SRC_MCK);
  assign head_ready = head_valid && head_done && !head_exc && !nmi;

  always_comb begin
    vec  = '0;
    srr0 = '0;
    case (src)
      SRC_RST, SRC_MCK: begin
        vec  = (src == SRC_RST) ? VEC_RESET : VEC_MCHECK;
        srr0 = head_valid ? head_pc : fetch_pc;
      end
      SRC_SYNC: begin
        vec  = sync_vector(cause_u);
        srr0 = resumes_after(cause_u) ? head_pc + AW'(ILEN) : head_pc;
      end
      SRC_EXT, SRC_DEC: begin
        vec  = (src == SRC_EXT) ? VEC_EXTIRQ : VEC_TIMER;
        srr0 = head_valid ? head_npc : fetch_pc;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/exc_retire_ctrl.sv
module exc_retire_ctrl
  import exc_retire_pkg::*;
#(
  parameter int            AW        = 32,
  parameter int            MW        = 32,
  parameter int            CW        = 4,
  parameter int            ILEN      = 4,
  parameter int            EE_BIT    = 15,
  parameter int            RI_BIT    = 1,
  parameter logic [MW-1:0] RESET_MSR = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             head_valid,
  output logic             head_ready,
  input  logic             head_done,
  input  logic             head_exc,
  input  logic [CW-1:0]    head_cause,
  input  logic [AW-1:0]    head_pc,
  input  logic [AW-1:0]    head_npc,
  input  logic [AW-1:0]    fetch_pc,
  input  logic             rst_req,
  input  logic             mck_req,
  input  logic             ext_req,
  input  logic             dec_req,
  input  logic             ret_valid,
  input  logic [MW-1:0]    ret_msr,
  output logic             take_o,
  output logic             flush_o,
  output logic [VEC_W-1:0] vec_o,
  output logic [AW-1:0]    srr0_o,
  output logic [MW-1:0]    srr1_o,
  output logic [MW-1:0]    msr_o
);
  localparam int NSRC = 3; // machine check, external, timer

  exc_src_e        src;
  logic [NSRC-1:0] req_v, clr_v, eff_v;
  logic [MW-1:0]   msr_q;
  logic            busy_q;

  assign req_v = {dec_req, ext_req, mck_req};
  assign clr_v = {src == SRC_DEC, src == SRC_EXT, src == SRC_MCK};

  exc_async_latch #(.N(NSRC)) u_latch (
    .clk(clk), .rst_n(rst_n), .req(req_v), .clr(clr_v), .eff(eff_v)
  );

  exc_arbiter #(.AW(AW), .CW(CW), .ILEN(ILEN)) u_arb (
    .head_valid(head_valid), .head_done(head_done), .head_exc(head_exc),
    .head_cause(head_cause), .head_pc(head_pc), .head_npc(head_npc),
    .fetch_pc(fetch_pc), .rst_req(rst_req), .mck_eff(eff_v[0]),
    .ext_eff(eff_v[1]), .dec_eff(eff_v[2]), .ee(msr_q[EE_BIT]),
    .busy(busy_q), .src(src), .head_ready(head_ready), .vec(vec_o),
    .srr0(srr0_o)
  );

  exc_msr_state #(.MW(MW), .EE_BIT(EE_BIT), .RI_BIT(RI_BIT), .RESET_MSR(RESET_MSR)) u_state (
    .clk(clk), .rst_n(rst_n), .take(take_o), .ret_valid(ret_valid),
    .ret_msr(ret_msr), .msr_q(msr_q), .busy_q(busy_q)
  );

  assign take_o  = (src != SRC_NONE);
  assign flush_o = take_o;
  assign srr1_o  = msr_q;
  assign msr_o   = msr_q;

  assert_busy_override_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && busy_q) |-> (vec_o == VEC_RESET || vec_o == VEC_MCHECK));

  assert_ext_needs_ee_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && (vec_o == VEC_EXTIRQ || vec_o == VEC_TIMER)) |-> msr_o[EE_BIT]);

  assert_retire_clean_R11: assert property (@(posedge clk) disable iff (!rst_n)
    head_ready |-> (head_valid && head_done && !head_exc));

  assert_retire_vs_take_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (head_ready && take_o) |-> (vec_o == VEC_EXTIRQ || vec_o == VEC_TIMER));
endmodule

// File: tb/exc_retire_ctrl_tb.sv
module exc_retire_ctrl_tb;
  logic clk = 0, rst_n = 0;
  logic head_valid = 0, head_done = 0, head_exc = 0;
  logic [3:0] head_cause = 0;
  logic [31:0] head_pc = 0, head_npc = 0, fetch_pc = 0, ret_msr = 0;
  logic rst_req = 0, mck_req = 0, ext_req = 0, dec_req = 0, ret_valid = 0;
  logic head_ready, take_o, flush_o;
  logic [11:0] vec_o;
  logic [31:0] srr0_o, srr1_o, msr_o;

  int checks = 0, errors = 0;

  // behavioural model state
  logic [31:0] m_msr;
  bit m_busy, m_mck, m_ext, m_dec;

  always #4 clk = ~clk;

  exc_retire_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .head_valid(head_valid), .head_ready(head_ready),
    .head_done(head_done), .head_exc(head_exc), .head_cause(head_cause),
    .head_pc(head_pc), .head_npc(head_npc), .fetch_pc(fetch_pc),
    .rst_req(rst_req), .mck_req(mck_req), .ext_req(ext_req), .dec_req(dec_req),
    .ret_valid(ret_valid), .ret_msr(ret_msr), .take_o(take_o), .flush_o(flush_o),
    .vec_o(vec_o), .srr0_o(srr0_o), .srr1_o(srr1_o), .msr_o(msr_o)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // compare one cycle against the model, then advance one clock
  task automatic step(string tag);
    bit e_mck, e_ext, e_dec, sync_ok, win, x_take, x_ready;
    int src; // 0 none 1 rst 2 mck 3 sync 4 ext 5 dec
    logic [11:0] x_vec;
    logic [31:0] x_srr0;
    #2;
    e_mck = m_mck | mck_req; e_ext = m_ext | ext_req; e_dec = m_dec | dec_req;
    sync_ok = head_valid && head_done && head_exc && !m_busy;
    win = m_msr[15] && !m_busy && (!head_valid || (head_done && !head_exc));
    if (rst_req) src = 1;
    else if (e_mck) src = 2;
    else if (sync_ok) src = 3;
    else if (win && e_ext) src = 4;
    else if (win && e_dec) src = 5;
    else src = 0;
    x_take = (src != 0);
    x_ready = head_valid && head_done && !head_exc && src != 1 && src != 2;
    x_vec = 0; x_srr0 = 0;
    case (src)
      1: begin x_vec = 12'h100; x_srr0 = head_valid ? head_pc : fetch_pc; end
      2: begin x_vec = 12'h200; x_srr0 = head_valid ? head_pc : fetch_pc; end
      3: begin
        x_vec = (head_cause == 0) ? 12'h300 : (head_cause == 4) ? 12'hC00 : 12'h700;
        x_srr0 = (head_cause == 3 || head_cause == 4) ? head_pc + 4 : head_pc;
      end
      4: begin x_vec = 12'h500; x_srr0 = head_valid ? head_npc : fetch_pc; end
      5: begin x_vec = 12'h900; x_srr0 = head_valid ? head_npc : fetch_pc; end
      default: ;
    endcase
    chk(tag, "take", 32'(take_o), 32'(x_take));
    chk(tag, "flush (R9)", 32'(flush_o), 32'(x_take));
    chk(tag, "head_ready (R11)", 32'(head_ready), 32'(x_ready));
    chk(tag, "msr (R8)", msr_o, m_msr);
    if (x_take) begin
      chk(tag, "vector (R10)", 32'(vec_o), 32'(x_vec));
      chk(tag, "srr0", srr0_o, x_srr0);
      chk(tag, "srr1 (R8)", srr1_o, m_msr);
    end
    m_mck = e_mck && src != 2; m_ext = e_ext && src != 4; m_dec = e_dec && src != 5;
    if (x_take) begin m_msr = m_msr & ~32'h8002; m_busy = 1; end
    else if (ret_valid) begin m_msr = ret_msr; m_busy = 0; end
    @(posedge clk);
    @(negedge clk);
    rst_req = 0; mck_req = 0; ext_req = 0; dec_req = 0; ret_valid = 0;
  endtask

  task automatic head(bit v, bit d, bit e, int c, logic [31:0] pc);
    head_valid = v; head_done = d; head_exc = e; head_cause = 4'(c);
    head_pc = pc; head_npc = pc + 4;
  endtask

  task automatic do_ret(string tag, logic [31:0] m);
    ret_valid = 1; ret_msr = m; step(tag);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    m_msr = 0; m_busy = 0; m_mck = 0; m_ext = 0; m_dec = 0;
    fetch_pc = 32'h0000_4000;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R12 reset state
    step("R12");
    do_ret("R8", 32'h0000_8002);
    // plain retire, R11
    head(1, 1, 0, 0, 32'h1000); step("R11");
    // R4 ext waits for incomplete head, then taken with successor address
    head(1, 0, 0, 0, 32'h1004); ext_req = 1; step("R4");
    step("R4");
    head(1, 1, 0, 0, 32'h1004); step("R4");
    head(0, 0, 0, 0, 0); do_ret("R8", 32'h0000_8002);
    // R4 timer with empty queue uses fetch address
    dec_req = 1; step("R4");
    do_ret("R8", 32'h0000_8002);
    // R1 data access fault
    head(1, 1, 1, 0, 32'h2000); step("R1");
    do_ret("R6", 32'h0000_8002);
    // R2 trap and system call
    head(1, 1, 1, 3, 32'h2100); step("R2");
    do_ret("R2", 32'h0000_8002);
    head(1, 1, 1, 4, 32'h2200); step("R2");
    // R3 floating-point fault with imprecise mode bits set
    do_ret("R3", 32'h0000_8902);
    head(1, 1, 1, 2, 32'h2300); step("R3");
    // R6 busy: fault held, ext not taken
    head(1, 1, 1, 1, 32'h2400); ext_req = 1; step("R6");
    step("R6");
    // R7 machine check breaks in while busy
    mck_req = 1; step("R7");
    // R5 priority: everything at once
    do_ret("R5", 32'h0000_8002);
    rst_req = 1; mck_req = 1; dec_req = 1; step("R5");
    step("R5"); // machine check pending, busy
    do_ret("R5", 32'h0000_8002);
    step("R5"); // head fault beats pending ext and timer
    head(0, 0, 0, 0, 0); do_ret("R5", 32'h0000_8002);
    step("R5"); // ext before timer
    do_ret("R5", 32'h0000_8002);
    step("R5"); // timer
    // R4 masked by interrupt enable, then released
    do_ret("R4", 32'h0000_0002);
    ext_req = 1; step("R4");
    step("R4");
    do_ret("R4", 32'h0000_8002);
    step("R4");
    // R10 unlisted cause
    do_ret("R10", 32'h0000_8002);
    head(1, 1, 1, 9, 32'h3000); step("R10");
    do_ret("R10", 32'h0000_8002);
    // randomized phase against the model, R5 R9
    for (int i = 0; i < 3000; i++) begin
      head($urandom % 4 != 0, $urandom % 2 == 0, $urandom % 4 == 0,
           $urandom % 8, {$urandom} & 32'hFFFF_FFFC);
      fetch_pc = {$urandom} & 32'hFFFF_FFFC;
      rst_req = ($urandom % 40 == 0); mck_req = ($urandom % 30 == 0);
      ext_req = ($urandom % 8 == 0); dec_req = ($urandom % 8 == 0);
      ret_valid = ($urandom % 5 == 0);
      ret_msr = {$urandom} | (($urandom % 3 != 0) ? 32'h8000 : 32'h0);
      step("R9");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule